// File: doc/BRIEF.md
# Time-Slot Switch Configuration Sequencer

This block drives the twelve on/off switching elements of one five-port circuit-switched network switch. It does no per-packet arbitration. A precomputed schedule is held in a small table with one row per time slot and one bit per element. A slot timer, kept in step with every other switch through a shared sync pulse, replays the rows in order. At each slot boundary the element outputs take the row of the slot that is starting and then hold it for the whole slot.

The five ports are north, east, south, west and local. Routing is dimension-ordered: a path that travels north or south never turns east or west, so those four turns have no element. Straight-through paths need no element. The twelve elements are the remaining turns, covering injection from and ejection to the local port and the four west/east-to-north/south turns. A checker flags any row that sends two inputs into one output, or one input into two outputs, in the same slot.

The table is loaded over a valid/ready write port. The port accepts a write only while the sequencer is disabled, and while disabled every element is held off. The slot timer keeps running while disabled, so the sequencer stays aligned with the rest of the network.

Top module: `tslot_switch_seq`

## Requirements
- R1: In reset, `elem_o`, `slot_o` and `conflict_o` are 0 and every table row is all zeros.
- R2: Without a sync pulse, `slot_o` advances by one every `SLOT_CYCLES` clocks and wraps from `SLOTS-1` to 0.
- R3: A clock with `sync_i` high sets `slot_o` to 0 and starts a full slot 0 at the next edge. This also holds when the sync falls in the last cycle of a slot, so sync wins over the natural boundary.
- R4: While `enable_i` is high, `elem_o` changes only on the edge that starts a slot. After that edge it equals the table row for the new `slot_o`.
- R5: After any clock with `enable_i` low, `elem_o` and `conflict_o` are 0. When enable is raised mid-slot, the outputs stay 0 until the next slot boundary.
- R6: `wr_ready_o` equals the inverse of `enable_i`. A write with `wr_valid_i` and `wr_ready_o` both high stores `wr_data_i` into row `wr_addr_i`. A write presented while enabled is dropped and leaves the row unchanged.
- R7: Element bit map (bit: input to output): 0..3 local to N,E,S,W; 4..7 N,E,S,W to local; 8 W to N; 9 W to S; 10 E to N; 11 E to S. `conflict_o` is registered with `elem_o`. It is 1 exactly when the applied row has two set bits sharing an output port, or two sharing an input port.
- R8: A write to an address of `SLOTS` or more is accepted and has no effect on any row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TDM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Global slot sync pulse, restarts at slot 0 |
| enable_i | input | 1 | Replay schedule when high, hold elements off when low |
| wr_valid_i | input | 1 | Table write request |
| wr_ready_o | output | 1 | Table write accepted this cycle if valid |
| wr_addr_i | input | 4 | Row (slot) index for the write |
| wr_data_i | input | 12 | Row contents, one bit per element |
| slot_o | output | 4 | Current slot index |
| elem_o | output | 12 | Element on/off controls for the current slot |
| conflict_o | output | 1 | Applied row has an output or input collision |

## Verification
The slot timer's natural boundary and the global sync pulse can land in the same clock. The bench waits until its reference model reports the last cycle of a slot, then raises sync there. It judges that slot 0 starts, not the following slot, and that the slot-0 row is applied with a full-length slot. Enable can also change in the same cycle as a boundary or mid-slot. Those cases are provoked by dropping and raising enable at chosen offsets, and the outputs are compared against the model on every cycle.

// File: rtl/tslot_pkg.sv
package tslot_pkg;
  localparam int NUM_PORTS = 5;
  localparam int NUM_ELEMS = 12;

  typedef enum logic [2:0] {
    P_NORTH = 3'd0,
    P_EAST  = 3'd1,
    P_SOUTH = 3'd2,
    P_WEST  = 3'd3,
    P_LOCAL = 3'd4
  } port_e;

  // Output port driven by each element
  function automatic port_e elem_dst(input int idx);
    case (idx)
      0, 8, 10: elem_dst = P_NORTH;
      1:        elem_dst = P_EAST;
      2, 9, 11: elem_dst = P_SOUTH;
      3:        elem_dst = P_WEST;
      default:  elem_dst = P_LOCAL;
    endcase
  endfunction

  // Input port feeding each element
  function automatic port_e elem_src(input int idx);
    case (idx)
      4:        elem_src = P_NORTH;
      5, 10, 11: elem_src = P_EAST;
      6:        elem_src = P_SOUTH;
      7, 8, 9:  elem_src = P_WEST;
      default:  elem_src = P_LOCAL;
    endcase
  endfunction
endpackage

// File: rtl/tslot_timer.sv
module tslot_timer #(
  parameter int SLOTS       = 15,
  parameter int SLOT_CYCLES = 4,
  localparam int SW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOT_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  output logic [SW-1:0] slot_o,
  output logic [SW-1:0] next_slot_o,
  output logic          bound_o
);
  logic [CW-1:0] cyc_q;
  logic [SW-1:0] slot_q;
  logic          last_cyc;
  logic          last_slot;

  assign last_cyc  = (cyc_q == CW'(SLOT_CYCLES - 1));
  assign last_slot = (slot_q == SW'(SLOTS - 1));
  assign bound_o   = sync_i | last_cyc;

  always_comb begin
    if (sync_i)        next_slot_o = '0;
    else if (!last_cyc) next_slot_o = slot_q;
    else if (last_slot) next_slot_o = '0;
    else               next_slot_o = slot_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else begin
      slot_q <= next_slot_o;
      if (bound_o) cyc_q <= '0;
      else         cyc_q <= cyc_q + CW'(1);
    end
  end

  assign slot_o = slot_q;

  assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < SW'(SLOTS));

  assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_i && last_cyc && !last_slot) |=> (slot_q == $past(slot_q) + SW'(1)));

  assert_sync_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (slot_q == '0 && cyc_q == '0));
endmodule

// File: rtl/tslot_table.sv
module tslot_table #(
  parameter int SLOTS = 15,
  parameter int ELEMS = 12,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [SW-1:0]    waddr_i,
  input  logic [ELEMS-1:0] wdata_i,
  input  logic [SW-1:0]    raddr_i,
  output logic [ELEMS-1:0] rdata_o
);
  logic [ELEMS-1:0] rows [SLOTS];

  for (genvar r = 0; r < SLOTS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                rows[r] <= '0;
      else if (we_i && waddr_i == SW'(r))        rows[r] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < SLOTS; r++)
      if (raddr_i == SW'(r)) rdata_o = rows[r];
  end
endmodule

// File: rtl/tslot_row_check.sv
module tslot_row_check
  import tslot_pkg::*;
(
  input  logic [NUM_ELEMS-1:0] row_i,
  output logic                 conflict_o
);
  logic [NUM_PORTS-1:0] out_clash;
  logic [NUM_PORTS-1:0] in_clash;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_comb begin
      int n_out;
      int n_in;
      n_out = 0;
      n_in  = 0;
      for (int i = 0; i < NUM_ELEMS; i++) begin
        if (row_i[i] && elem_dst(i) == port_e'(p)) n_out++;
        if (row_i[i] && elem_src(i) == port_e'(p)) n_in++;
      end
      out_clash[p] = (n_out > 1);
      in_clash[p]  = (n_in > 1);
    end
  end

  assign conflict_o = |out_clash | |in_clash;
endmodule

// File: rtl/tslot_switch_seq.sv
module tslot_switch_seq
  import tslot_pkg::*;
#(
  parameter int SLOTS       = 15,
  parameter int SLOT_CYCLES = 4,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_i,
  input  logic                 enable_i,
  input  logic                 wr_valid_i,
  output logic                 wr_ready_o,
  input  logic [SW-1:0]        wr_addr_i,
  input  logic [NUM_ELEMS-1:0] wr_data_i,
  output logic [SW-1:0]        slot_o,
  output logic [NUM_ELEMS-1:0] elem_o,
  output logic                 conflict_o
);
  logic [SW-1:0]        next_slot;
  logic                 bound;
  logic [NUM_ELEMS-1:0] row;
  logic                 row_conflict;
  logic                 we;
  logic [NUM_ELEMS-1:0] elem_q;
  logic                 conf_q;

  assign wr_ready_o = !enable_i;
  assign we = wr_valid_i && wr_ready_o && (wr_addr_i < SW'(SLOTS));

  tslot_timer #(.SLOTS(SLOTS), .SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
    .slot_o(slot_o), .next_slot_o(next_slot), .bound_o(bound)
  );

  tslot_table #(.SLOTS(SLOTS), .ELEMS(NUM_ELEMS)) u_table (
    .clk(clk), .rst_n(rst_n), .we_i(we), .waddr_i(wr_addr_i),
    .wdata_i(wr_data_i), .raddr_i(next_slot), .rdata_o(row)
  );

  tslot_row_check u_check (.row_i(row), .conflict_o(row_conflict));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q <= '0;
      conf_q <= 1'b0;
    end else if (!enable_i) begin
      elem_q <= '0;
      conf_q <= 1'b0;
    end else if (bound) begin
      elem_q <= row;
      conf_q <= row_conflict;
    end
  end

  assign elem_o     = elem_q;
  assign conflict_o = conf_q;

  assert_hold_midslot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !bound) |=> $stable(elem_o));

  assert_off_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (elem_o == '0 && !conflict_o));

  assert_conflict_needs_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |-> ($countones(elem_o) >= 2));
endmodule

// File: tb/tslot_switch_seq_tb.sv
module tslot_switch_seq_tb;
  localparam int T  = 15;
  localparam int SC = 4;
  localparam int SW = $clog2(T);

  logic clk = 0;
  logic rst_n = 0;
  logic sync_i = 0, enable_i = 0, wr_valid_i = 0;
  logic [SW-1:0] wr_addr_i = '0;
  logic [11:0] wr_data_i = '0;
  logic wr_ready_o, conflict_o;
  logic [SW-1:0] slot_o;
  logic [11:0] elem_o;

  int vectors = 0, errors = 0, cycles = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  tslot_switch_seq #(.SLOTS(T), .SLOT_CYCLES(SC)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .enable_i(enable_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .slot_o(slot_o), .elem_o(elem_o), .conflict_o(conflict_o)
  );

  // Reference model (R7 map: output and input port of each element)
  int dst_map [12] = '{0, 1, 2, 3, 4, 4, 4, 4, 0, 2, 0, 2};
  int src_map [12] = '{4, 4, 4, 4, 0, 1, 2, 3, 3, 3, 1, 1};
  int m_cyc = 0, m_slot = 0;
  logic [11:0] m_tbl [T];
  logic [11:0] m_elem = '0;
  logic m_conf = 0;

  function automatic logic clash(input logic [11:0] r);
    int no [5];
    int ni [5];
    clash = 0;
    for (int p = 0; p < 5; p++) begin no[p] = 0; ni[p] = 0; end
    for (int i = 0; i < 12; i++)
      if (r[i]) begin no[dst_map[i]]++; ni[src_map[i]]++; end
    for (int p = 0; p < 5; p++) if (no[p] > 1 || ni[p] > 1) clash = 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_slot = 0; m_elem = '0; m_conf = 0;
      for (int r = 0; r < T; r++) m_tbl[r] = '0;
    end else begin
      bit bnd;
      int ns;
      bnd = sync_i || (m_cyc == SC - 1);
      if (sync_i) ns = 0;
      else if (m_cyc == SC - 1) ns = (m_slot == T - 1) ? 0 : m_slot + 1;
      else ns = m_slot;
      if (!enable_i) begin m_elem = '0; m_conf = 0; end
      else if (bnd) begin m_elem = m_tbl[ns]; m_conf = clash(m_tbl[ns]); end
      if (wr_valid_i && !enable_i && int'(wr_addr_i) < T) m_tbl[wr_addr_i] = wr_data_i;
      m_cyc = bnd ? 0 : m_cyc + 1;
      m_slot = ns;
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (!rst_n) begin
      if (elem_o !== '0 || slot_o !== '0 || conflict_o !== 0) begin
        errors++;
        $display("FAIL R1 reset outputs elem=%h slot=%0d conf=%b expected 000/0/0",
                 elem_o, slot_o, conflict_o);
      end
    end else begin
      if (int'(slot_o) != m_slot) begin
        errors++;
        $display("FAIL %s (R2) slot=%0d expected %0d", phase, slot_o, m_slot);
      end
      if (elem_o !== m_elem) begin
        errors++;
        $display("FAIL %s (R4) elem=%h expected %h", phase, elem_o, m_elem);
      end
      if (conflict_o !== m_conf) begin
        errors++;
        $display("FAIL %s (R7) conflict=%b expected %b", phase, conflict_o, m_conf);
      end
      if (wr_ready_o !== !enable_i) begin
        errors++;
        $display("FAIL %s (R6) ready=%b expected %b", phase, wr_ready_o, !enable_i);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d expected finish earlier", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input int a, input logic [11:0] d);
    wr_valid_i = 1; wr_addr_i = SW'(a); wr_data_i = d;
    step(1);
    wr_valid_i = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    phase = "R1";
    step(2);
    enable_i = 1;              // R1: empty table replays zero rows
    step(SC * 3);
    enable_i = 0;
    step(1);
    phase = "R6";              // load: one-hot rows, then colliding rows
    for (int r = 0; r < T; r++) begin
      wr(r, (r < 12) ? 12'(1 << r) : ((r == 12) ? 12'h301 : 12'h0A4));
      if (r % 4 == 3) step(1);
    end
    phase = "R8";              // out-of-range address ignored
    wr(T, 12'hFFF);
    step(1);
    phase = "R3";
    sync_i = 1; step(1); sync_i = 0;
    enable_i = 1;
    phase = "R2";
    step(T * SC * 3 + 5);
    phase = "R6";              // writes while enabled are dropped
    for (int k = 0; k < 6; k++) wr(2 + k, 12'hFFF);
    step(T * SC);
    phase = "R3";              // sync mid-slot
    while (m_cyc != 1) step(1);
    sync_i = 1; step(1); sync_i = 0;
    step(SC * 3);
    while (m_cyc != SC - 1) step(1);   // sync on the natural boundary
    sync_i = 1; step(1); sync_i = 0;
    step(SC * 5);
    phase = "R5";
    while (m_cyc != 1) step(1);
    enable_i = 0; step(2);
    enable_i = 1; step(SC * 2);
    while (m_cyc != SC - 1) step(1);   // disable exactly at a boundary
    enable_i = 0; step(1);
    enable_i = 1; step(SC * 3);
    enable_i = 0;
    phase = "R7";              // reload with mixed rows
    for (int r = 0; r < T; r++) wr(r, 12'(12'h5A3 ^ (r * 12'h137)));
    step(2);
    enable_i = 1;
    step(T * SC * 2 + 3);
    enable_i = 0;
    step(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule